// File: doc/BRIEF.md
# DMA Global Control Register with Transfer Pacer

This block holds the 16-bit global control and status word of a multi-channel DMA controller. Software reads and writes the word over a simple single-register bus. The word carries a master enable, a two-bit channel priority field, a two-bit pacing code for cycle-steal transfers, and two sticky error flags. An address-error flag and an NMI flag are each set by a one-cycle pulse from elsewhere in the controller.

From that state the block makes a per-cycle transfer-permit strobe for the channel logic. With the pacing code at one of its intermittent settings and every channel in cycle-steal mode, at most one transfer is permitted per window of 16 or 64 bus clocks. Otherwise each request is passed straight through. The strobe is held low while the controller is disabled or while an error flag is up. An error flag is cleared only by writing 0 to it after a read has returned it as 1. This stops a careless write from discarding an error that software has never seen.

Top module: `dma_opctl_pacer`

## Requirements
- R1: After reset the read word is 0x0000, and `dma_enable`, `prio_mode` and `xfer_permit` are 0.
- R2: Bit positions of the read word: pacing code in bits 13:12, priority field in bits 9:8, address-error flag in bit 2, NMI flag in bit 1, master enable in bit 0. Every other bit reads 0, and writing 1 to those bits has no effect.
- R3: A write loads the pacing code, the priority field and the master enable from the same bit positions. They appear on `dma_enable` and `prio_mode` from the next cycle, and hold while no write occurs.
- R4: `xfer_permit` is 0 in any cycle where the master enable is 0 or either error flag is 1.
- R5: With the gate open, `xfer_permit` equals `xfer_req` in every cycle when the pacing code is 00 or 01 (01 behaves as 00), or when `all_chan_cycle_steal` is 0.
- R6: With pacing code 10 and `all_chan_cycle_steal` = 1, a permit issued in cycle t is followed by no further permit before cycle t+16. A request that is pending is permitted from t+16 on.
- R7: With pacing code 11 and `all_chan_cycle_steal` = 1, the spacing is 64 cycles in the same way as R6.
- R8: When the effective pacing setting changes (code or `all_chan_cycle_steal`), the interval restarts. The first request in the new intermittent setting is permitted at once.
- R9: A pulse on `addr_err_pulse` sets bit 2, and a pulse on `nmi_pulse` sets bit 1. Both flags are sticky. Writing 1 to a flag has no effect, and writing 0 to a flag that no read has returned as 1 since it was set leaves it set.
- R10: A write of 0 to a flag that was earlier read as 1 clears it in the next cycle.
- R11: A set pulse in the same cycle as a clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_rd_en | input | 1 | Read strobe; arms the flag clear qualifiers |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current control and status word |
| addr_err_pulse | input | 1 | One-cycle pulse that sets the address-error flag |
| nmi_pulse | input | 1 | One-cycle pulse that sets the NMI flag |
| all_chan_cycle_steal | input | 1 | High when every channel is in cycle-steal bus mode |
| xfer_req | input | 1 | Transfer request from the channel logic |
| xfer_permit | output | 1 | Transfer allowed in this cycle |
| dma_enable | output | 1 | Master enable |
| prio_mode | output | 2 | Channel priority field |

## Verification
The embedded assertions check on every cycle that no permit escapes a closed gate, that a paced permit never comes sooner than the interval after the one before, that a changed setting lets the first request through, that flags stay set unless an armed zero write arrives, and that a set pulse always wins. Only the bench's scenarios can show the exact number of permits over long request bursts in each mode. They also show that code 01 passes requests like normal mode, that reserved bits read back as 0 after writing all ones, and the full read-then-clear order on each flag, all compared against a behavioural model cycle by cycle.

// File: rtl/dmaop_pkg.sv
`timescale 1ns/1ps
package dmaop_pkg;

  localparam int WORD_W   = 16;
  localparam int CMS_LO   = 12;
  localparam int PR_LO    = 8;
  localparam int FLAG_LSB = 1;   // index 0 -> NMI (bit 1), index 1 -> address error (bit 2)
  localparam int NUM_FLAGS = 2;
  localparam int DME_BIT  = 0;

  typedef enum logic [1:0] {
    PACE_OFF  = 2'b00,
    PACE_RSVD = 2'b01,
    PACE_16   = 2'b10,
    PACE_64   = 2'b11
  } pace_code_e;

  typedef enum logic [1:0] {
    EFF_FREE  = 2'b00,
    EFF_SHORT = 2'b01,
    EFF_LONG  = 2'b10
  } pace_eff_e;

  typedef struct packed {
    pace_code_e  cms;
    logic [1:0]  prio;
    logic        dme;
  } ctrl_t;

endpackage

// File: rtl/dmaop_rst_sync.sv
`timescale 1ns/1ps
module dmaop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  // Assert asynchronously, release after STAGES clean edges.
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dmaop_ctrl_reg.sv
`timescale 1ns/1ps
module dmaop_ctrl_reg
  import dmaop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] cms_wr,
  input  logic [1:0] prio_wr,
  input  logic       dme_wr,
  output ctrl_t      ctrl_o
);
  ctrl_t ctrl_q, ctrl_n;
  logic  ctrl_en;

  // Next-state: a write replaces all three fields together.
  always_comb begin
    ctrl_en     = wr_en;
    ctrl_n      = ctrl_q;
    ctrl_n.cms  = pace_code_e'(cms_wr);
    ctrl_n.prio = prio_wr;
    ctrl_n.dme  = dme_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_n;
  end

  assign ctrl_o = ctrl_q;

  // R3: written fields appear one cycle after the write.
  p_write_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_q.dme == $past(dme_wr)) && (ctrl_q.prio == $past(prio_wr)));

  // R3: without a write the fields do not move.
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/dmaop_err_flag.sv
`timescale 1ns/1ps
module dmaop_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  input  logic rd_en,
  input  logic wr_en,
  input  logic wr_bit,
  output logic flag_o
);
  logic flag_q, flag_n;
  logic arm_q, arm_n;
  logic zero_wr;
  logic clr_ok;
  logic st_en;

  always_comb begin
    zero_wr = wr_en && !wr_bit;
    clr_ok  = zero_wr && arm_q;
    // Set has priority over an armed clear.
    if (set_pulse)   flag_n = 1'b1;
    else if (clr_ok) flag_n = 1'b0;
    else             flag_n = flag_q;
    // Qualifier: set by a read that sees 1, spent by any zero write.
    arm_n = flag_n && ((arm_q && !zero_wr) || (rd_en && flag_q));
    st_en = set_pulse || rd_en || wr_en || flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (st_en) begin
      flag_q <= flag_n;
      arm_q  <= arm_n;
    end
  end

  assign flag_o = flag_q;

  // R9: only a zero write can drop a set flag.
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_en && !wr_bit)) |=> flag_q);

  // R10: without a qualifying earlier read the flag survives.
  p_needs_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !arm_q) |=> flag_q);

  // R11: a set pulse always leaves the flag at 1.
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |=> flag_q);
endmodule

// File: rtl/dmaop_pacer.sv
`timescale 1ns/1ps
module dmaop_pacer
  import dmaop_pkg::*;
#(
  parameter int SHORT_GAP = 16,
  parameter int LONG_GAP  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pace_code_e pace_code,
  input  logic       all_cs,
  input  logic       gate_open,
  input  logic       req,
  output logic       permit
);
  localparam int CNT_W = $clog2(LONG_GAP + 1);
  localparam int SG_W  = CNT_W + 1;
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_GAP - 1);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_GAP - 1);

  pace_eff_e         eff, eff_q;
  logic              paced, changed, ready_now, grant;
  logic [CNT_W-1:0]  limit;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              ready_q, ready_n;
  logic              cnt_en;

  // Effective setting: intermittent only when every channel steals cycles.
  always_comb begin
    unique case (pace_code)
      PACE_16: eff = all_cs ? EFF_SHORT : EFF_FREE;
      PACE_64: eff = all_cs ? EFF_LONG  : EFF_FREE;
      default: eff = EFF_FREE;   // 00 and the prohibited 01
    endcase
    paced     = (eff != EFF_FREE);
    changed   = (eff != eff_q);
    limit     = (eff == EFF_LONG) ? LONG_LIM : SHORT_LIM;
    ready_now = changed || ready_q;
    grant     = req && gate_open && (!paced || ready_now);
  end

  // Interval counter next-state.
  always_comb begin
    cnt_n   = cnt_q;
    ready_n = ready_q;
    cnt_en  = 1'b1;
    if (!paced) begin
      cnt_n   = '0;
      ready_n = 1'b1;
    end else if (grant) begin
      cnt_n   = CNT_W'(1);
      ready_n = 1'b0;
    end else if (changed) begin
      cnt_n   = '0;
      ready_n = 1'b1;
    end else if (!ready_q) begin
      if (cnt_q == limit) ready_n = 1'b1;
      else                cnt_n   = cnt_q + CNT_W'(1);
    end else begin
      cnt_en  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q <= EFF_FREE;
    end else begin
      eff_q <= eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ready_q <= 1'b1;
    end else if (cnt_en) begin
      cnt_q   <= cnt_n;
      ready_q <= ready_n;
    end
  end

  assign permit = grant;

  // Checker: cycles since the last permit, saturating.
  logic [SG_W-1:0] sg_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sg_q <= '1;
    else if (grant)             sg_q <= SG_W'(1);
    else if (changed)           sg_q <= '1;
    else if (sg_q != '1)        sg_q <= sg_q + SG_W'(1);
  end

  // R6 / R7: paced permits are at least the interval apart.
  p_min_gap_r6_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (permit && paced && !changed) |-> (sg_q >= SG_W'(limit) + SG_W'(1)));

  // R8: a fresh intermittent setting lets the first request through.
  p_first_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (changed && paced && req && gate_open) |-> permit);

  // R5: unpaced requests pass straight through an open gate.
  p_passthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!paced && gate_open) |-> (permit == req));
endmodule

// File: rtl/dma_opctl_pacer.sv
`timescale 1ns/1ps
module dma_opctl_pacer
  import dmaop_pkg::*;
#(
  parameter int SHORT_GAP = 16,
  parameter int LONG_GAP  = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic        reg_rd_en,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        addr_err_pulse,
  input  logic        nmi_pulse,
  input  logic        all_chan_cycle_steal,
  input  logic        xfer_req,
  output logic        xfer_permit,
  output logic        dma_enable,
  output logic [1:0]  prio_mode
);
  logic                 rst_sync_n;
  ctrl_t                ctrl;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flags;
  logic                 gate_open;
  logic                 unused_rsvd;

  // Reserved write bits are dropped on purpose.
  assign unused_rsvd = &{1'b0, reg_wdata[15:14], reg_wdata[11:10], reg_wdata[7:3]};

  dmaop_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  dmaop_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_wr_en),
    .cms_wr  (reg_wdata[CMS_LO +: 2]),
    .prio_wr (reg_wdata[PR_LO +: 2]),
    .dme_wr  (reg_wdata[DME_BIT]),
    .ctrl_o  (ctrl)
  );

  assign flag_set = {addr_err_pulse, nmi_pulse};

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    dmaop_err_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .set_pulse (flag_set[g]),
      .rd_en     (reg_rd_en),
      .wr_en     (reg_wr_en),
      .wr_bit    (reg_wdata[FLAG_LSB + g]),
      .flag_o    (flags[g])
    );
  end

  assign gate_open = ctrl.dme && (flags == '0);

  dmaop_pacer #(.SHORT_GAP(SHORT_GAP), .LONG_GAP(LONG_GAP)) u_pacer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pace_code (ctrl.cms),
    .all_cs    (all_chan_cycle_steal),
    .gate_open (gate_open),
    .req       (xfer_req),
    .permit    (xfer_permit)
  );

  // Read image.
  always_comb begin
    reg_rdata                          = '0;
    reg_rdata[CMS_LO +: 2]             = ctrl.cms;
    reg_rdata[PR_LO +: 2]              = ctrl.prio;
    reg_rdata[FLAG_LSB +: NUM_FLAGS]   = flags;
    reg_rdata[DME_BIT]                 = ctrl.dme;
  end

  assign dma_enable = ctrl.dme;
  assign prio_mode  = ctrl.prio;

  // R4: no permit while disabled or while an error is pending.
  p_gate_closed_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    xfer_permit |-> (reg_rdata[DME_BIT] && !reg_rdata[2] && !reg_rdata[1]));

  // R2: a write never makes a reserved bit read back as 1.
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_wr_en |=> (reg_rdata[15:14] == 2'b00) && (reg_rdata[11:10] == 2'b00)
                  && (reg_rdata[7:3] == 5'b00000));
endmodule

// File: tb/tb_dma_opctl_pacer.sv
`timescale 1ns/1ps
module tb_dma_opctl_pacer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en, reg_rd_en;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        addr_err_pulse, nmi_pulse, all_chan_cycle_steal, xfer_req;
  logic        xfer_permit, dma_enable;
  logic [1:0]  prio_mode;

  always #10 clk = ~clk;   // 50 MHz

  dma_opctl_pacer dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_err_pulse(addr_err_pulse),
    .nmi_pulse(nmi_pulse), .all_chan_cycle_steal(all_chan_cycle_steal),
    .xfer_req(xfer_req), .xfer_permit(xfer_permit), .dma_enable(dma_enable),
    .prio_mode(prio_mode)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int grant_cnt = 0;

  // Behavioural reference state.
  int m_cms, m_pr, m_dme, m_ae, m_nmi, m_ae_arm, m_nmi_arm, m_prev_eff;
  longint m_last, cyc;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int eff_of();
    if (all_chan_cycle_steal) begin
      if (m_cms == 2) return 16;
      if (m_cms == 3) return 64;
    end
    return 0;
  endfunction

  function automatic bit exp_grant();
    int e;
    e = eff_of();
    if (!xfer_req || !m_dme || m_ae != 0 || m_nmi != 0) return 1'b0;
    if (e == 0 || e != m_prev_eff) return 1'b1;
    return (cyc - m_last) >= e;
  endfunction

  function automatic int exp_image();
    return (m_cms << 12) | (m_pr << 8) | (m_ae << 2) | (m_nmi << 1) | m_dme;
  endfunction

  // Reference update at each active edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cms = 0; m_pr = 0; m_dme = 0; m_ae = 0; m_nmi = 0;
      m_ae_arm = 0; m_nmi_arm = 0; m_prev_eff = 0; m_last = -100000; cyc = 0;
    end else begin
      int e, n_ae, n_nmi, n_aa, n_na;
      bit g, zw_ae, zw_nmi;
      g = exp_grant();
      e = eff_of();
      if (e != 0 && g) m_last = cyc;
      else if (e != m_prev_eff) m_last = -100000;
      m_prev_eff = e;
      zw_ae  = reg_wr_en && !reg_wdata[2];
      zw_nmi = reg_wr_en && !reg_wdata[1];
      n_ae  = addr_err_pulse ? 1 : (zw_ae && m_ae_arm != 0) ? 0 : m_ae;
      n_nmi = nmi_pulse      ? 1 : (zw_nmi && m_nmi_arm != 0) ? 0 : m_nmi;
      n_aa = (n_ae != 0 && ((m_ae_arm != 0 && !zw_ae) || (reg_rd_en && m_ae != 0))) ? 1 : 0;
      n_na = (n_nmi != 0 && ((m_nmi_arm != 0 && !zw_nmi) || (reg_rd_en && m_nmi != 0))) ? 1 : 0;
      m_ae = n_ae; m_nmi = n_nmi; m_ae_arm = n_aa; m_nmi_arm = n_na;
      if (reg_wr_en) begin
        m_cms = int'(reg_wdata[13:12]);
        m_pr  = int'(reg_wdata[9:8]);
        m_dme = int'(reg_wdata[0]);
      end
      cyc++;
    end
  end

  // Per-cycle comparison, 5 ns after the inputs change.
  always begin
    @(negedge clk);
    #5;
    if (rst_n && !done) begin
      string tag;
      bit ep;
      int e;
      ep = exp_grant();
      e  = eff_of();
      if (!m_dme || m_ae != 0 || m_nmi != 0) tag = "R4";
      else if (e == 16) tag = "R6";
      else if (e == 64) tag = "R7";
      else tag = "R5";
      chk(xfer_permit == ep, tag, int'(xfer_permit), int'(ep));
      chk(reg_rdata == 16'(exp_image()), "R2", int'(reg_rdata), exp_image());
      chk(dma_enable == m_dme[0] && prio_mode == 2'(m_pr), "R3",
          int'({prio_mode, dma_enable}), (m_pr << 1) | m_dme);
      if (xfer_permit) grant_cnt++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(output logic [15:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1;
    #5 d = reg_rdata;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic pulse(input bit ae, input bit nmi);
    @(negedge clk);
    addr_err_pulse = ae; nmi_pulse = nmi;
    @(negedge clk);
    addr_err_pulse = 1'b0; nmi_pulse = 1'b0;
  endtask

  task automatic burst(input int n);
    grant_cnt = 0;
    @(negedge clk);
    xfer_req = 1'b1;
    repeat (n) @(negedge clk);
    xfer_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    logic [15:0] rv;
    int lfsr;
    rst_n = 1'b0; reg_wr_en = 0; reg_rd_en = 0; reg_wdata = '0;
    addr_err_pulse = 0; nmi_pulse = 0; all_chan_cycle_steal = 1'b1; xfer_req = 0;
    idle(3);
    #5;
    chk(reg_rdata == 16'h0000 && !xfer_permit && !dma_enable && prio_mode == 2'b00,
        "R1", int'(reg_rdata), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    chk(reg_rdata == 16'h0000, "R1", int'(reg_rdata), 0);

    // All ones: reserved bits and flags must not stick.
    wr_reg(16'hFFFF);
    rd_reg(rv);
    chk(rv == 16'h3301, "R2", int'(rv), 16'h3301);
    chk(rv[2:1] == 2'b00, "R9", int'(rv[2:1]), 0);

    // Normal mode, every request passes.
    wr_reg(16'h0001);
    burst(10);
    chk(grant_cnt == 10, "R5", grant_cnt, 10);
    // Prohibited code 01 behaves as normal.
    wr_reg(16'h1001);
    burst(10);
    chk(grant_cnt == 10, "R5", grant_cnt, 10);

    // Interval 16: first permit immediately (R8), then spaced.
    @(negedge clk); reg_wr_en = 1'b1; reg_wdata = 16'h2001;
    @(negedge clk); reg_wr_en = 1'b0; reg_wdata = '0;
    grant_cnt = 0; xfer_req = 1'b1;
    #5 chk(xfer_permit == 1'b1, "R8", int'(xfer_permit), 1);
    repeat (40) @(negedge clk);
    xfer_req = 1'b0;
    chk(grant_cnt == 3, "R6", grant_cnt, 3);

    // Not all channels in cycle-steal: unthrottled.
    all_chan_cycle_steal = 1'b0;
    burst(10);
    chk(grant_cnt == 10, "R5", grant_cnt, 10);
    all_chan_cycle_steal = 1'b1;

    // Interval 64.
    wr_reg(16'h3201);
    burst(130);
    chk(grant_cnt == 3, "R7", grant_cnt, 3);
    chk(prio_mode == 2'b10, "R3", int'(prio_mode), 2);

    // Disabled: nothing passes.
    wr_reg(16'h0000);
    burst(10);
    chk(grant_cnt == 0, "R4", grant_cnt, 0);

    // Address-error flag.
    wr_reg(16'h0001);
    pulse(1'b1, 1'b0);
    burst(5);
    chk(grant_cnt == 0, "R4", grant_cnt, 0);
    wr_reg(16'h0001);            // zero write, never read: stays
    rd_reg(rv);
    chk(rv[2] == 1'b1, "R9", int'(rv[2]), 1);
    wr_reg(16'h0005);            // writing 1: no effect
    rd_reg(rv);
    chk(rv[2] == 1'b1, "R9", int'(rv[2]), 1);
    wr_reg(16'h0001);            // armed by the read: clears
    rd_reg(rv);
    chk(rv[2] == 1'b0, "R10", int'(rv[2]), 0);

    // NMI flag: set pulse coinciding with clearing write.
    pulse(1'b0, 1'b1);
    rd_reg(rv);
    chk(rv[1] == 1'b1, "R9", int'(rv[1]), 1);
    @(negedge clk); reg_wr_en = 1'b1; reg_wdata = 16'h0001; nmi_pulse = 1'b1;
    @(negedge clk); reg_wr_en = 1'b0; reg_wdata = '0; nmi_pulse = 1'b0;
    rd_reg(rv);
    chk(rv[1] == 1'b1, "R11", int'(rv[1]), 1);
    wr_reg(16'h0001);
    rd_reg(rv);
    chk(rv[1] == 1'b0, "R10", int'(rv[1]), 0);
    burst(4);
    chk(grant_cnt == 4, "R4", grant_cnt, 4);

    // Mixed stretch checked by the per-cycle model.
    lfsr = 32'h1ACE;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hA3000000 : 0);
      xfer_req = lfsr[0] | lfsr[3];
      if (i % 97 == 0) all_chan_cycle_steal = lfsr[5] | lfsr[6];
      reg_wr_en = (i % 150 == 149);
      reg_wdata = {2'b00, 2'(lfsr[9:8] | 2'b10), 2'b00, 2'(lfsr[11:10]), 7'b0, 1'b1};
      addr_err_pulse = (i == 420);
      reg_rd_en = (i == 430);
    end
    @(negedge clk);
    reg_wr_en = 0; xfer_req = 0; addr_err_pulse = 0; reg_rd_en = 0;
    wr_reg(16'h0001);
    rd_reg(rv);
    chk(rv[2] == 1'b0, "R10", int'(rv[2]), 0);
    idle(2);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule